// File: doc/BRIEF.md
# Minimax Threshold Clustering Engine

This block places a small number of decision thresholds over a larger set of interference offset levels. Software or a calibration sequencer loads up to `N_MAX` signed levels, already sorted from lowest to highest. It then asks for `M` groups. The engine splits the list into `M` contiguous runs so that the widest run is as narrow as possible. Each run's centre becomes one slicer threshold. Every level then has a known group, and its worst distance to its own threshold is half the reported span.

The search is a dynamic program over a cost table. The entry for "first `i` levels in `m` groups" takes the smallest value, over the size `k` of the last run, of the larger of two quantities: the width of that last run, and the table entry for the first `i-k` levels in `m-1` groups. The first row is simply the width from level 0 to level `i-1`. One candidate is evaluated per clock. The chosen last-run size is stored beside each cost. After the table is complete, a traceback pass walks those sizes from the last level back to the first and writes out the group boundaries and thresholds.

The state machine has four states. IDLE waits for `start`. FILL sweeps the cost table row by row. TRACE produces one group per cycle, from the highest group down to group 0. FIN raises `done` for one cycle. The transitions are:
- IDLE→FILL on an accepted start with a legal group count.
- IDLE→FIN on a start with an illegal group count.
- FILL→TRACE when the entry for all levels in `M` groups is written.
- TRACE→FIN after group 0.
- FIN→IDLE always.

Top module: `isi_group_solver`

## Requirements
- R1: A cycle with `load_en` high and `busy` low writes `load_level` into slot `load_idx`. Slots 0 to `lvl_count-1` are the sorted levels used by the next run.
- R2: With `grp_count` = 1, every level is placed in group 0. The span is the last level minus the first level, and the group 0 threshold is their sum.
- R3: After a successful run, `span_max` equals the smallest possible value of the widest group span, taken over all splits of the levels into `grp_count` contiguous non-empty groups.
- R4: `rd_thr` for group g equals the lowest member plus the highest member of that group. This is twice the midpoint, held as a signed value one bit wider than a level, so that no halving bit is lost.
- R5: Group numbers in `rd_lvl_grp` are non-decreasing with the level index. Level 0 is in group 0, level `lvl_count-1` is in group `grp_count-1`, and no group is empty.
- R6: When several last-group sizes give the same cost, the smallest last-group size is chosen. For example, levels 0, 5, 10 with two groups give groups {0,5} and {10} with span 5.
- R7: A start with `grp_count` equal to 0, greater than `lvl_count`, or greater than `G_MAX` makes `done` and `err` high on the cycle after the start. Span, thresholds and group numbers keep their previous values.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` lasts exactly one cycle and is never high together with `busy`. A `start` while busy has no effect on the result.
- R9: `load_en` while `busy` is high is ignored. The run's result is the one for the levels loaded before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Level write strobe |
| load_idx | input | IW | Level slot to write |
| load_level | input | LVL_W | Signed level value |
| lvl_count | input | CW | Number of levels used (1..N_MAX) |
| grp_count | input | GW | Requested number of groups |
| start | input | 1 | Begin a run (accepted in IDLE only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had an illegal group count |
| rd_grp_idx | input | GIW | Group whose threshold is read |
| rd_thr | output | LVL_W+1 | Twice the threshold of that group (signed) |
| rd_lvl_idx | input | IW | Level whose group is read |
| rd_lvl_grp | output | GIW | Group number of that level |
| span_max | output | LVL_W+1 | Minimax group span of the last good run |

## Verification
The embedded assertions check the following on every cycle:
- Candidate sizes stay within the window the recurrence allows, and every stored choice is non-zero.
- Each traceback step takes a legal run and ends exactly at level 0.
- Every group write has ordered bounds.
- `done` is a lone pulse exclusive with `busy`, and an illegal start goes straight to `done` with `err`.

Optimality, the exact thresholds, the tie rule, and the immunity to loads and starts during a run show only in the bench's scenarios. The bench sweeps small level counts, several level shapes and every legal group count, and compares each result against a recurrence evaluated in the bench.

// File: rtl/gsolv_pkg.sv
package gsolv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_TRACE,
        ST_FIN
    } gs_state_e;
endpackage

// File: rtl/gs_levels.sv
module gs_levels #(
    parameter int W     = 16,
    parameter int N_MAX = 32,
    parameter int IW    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic signed [W-1:0] wr_val,
    input  logic [IW-1:0]       rd_lo_idx,
    input  logic [IW-1:0]       rd_hi_idx,
    output logic signed [W-1:0] rd_lo,
    output logic signed [W-1:0] rd_hi
);
    logic signed [W-1:0] mem_q [N_MAX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N_MAX; j++) mem_q[j] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_val;
        end
    end

    assign rd_lo = mem_q[rd_lo_idx];
    assign rd_hi = mem_q[rd_hi_idx];

    assert_load_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < N_MAX));
endmodule

// File: rtl/gs_table.sv
module gs_table #(
    parameter int W     = 16,
    parameter int N_MAX = 32,
    parameter int G_MAX = 8,
    parameter int IW    = 5,
    parameter int GIW   = 3,
    parameter int CW    = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [GIW-1:0] wrow,
    input  logic [IW-1:0]  wcol,
    input  logic [W:0]     wcost,
    input  logic [CW-1:0]  warg,
    input  logic [GIW-1:0] arow,
    input  logic [IW-1:0]  acol,
    output logic [W:0]     acost,
    input  logic [GIW-1:0] brow,
    input  logic [IW-1:0]  bcol,
    output logic [W:0]     bcost,
    output logic [CW-1:0]  barg
);
    logic [W:0]    cost_q [G_MAX][N_MAX];
    logic [CW-1:0] arg_q  [G_MAX][N_MAX];

    always_ff @(posedge clk) begin
        if (we) begin
            cost_q[wrow][wcol] <= wcost;
            arg_q[wrow][wcol]  <= warg;
        end
    end

    assign acost = cost_q[arow][acol];
    assign bcost = cost_q[brow][bcol];
    assign barg  = arg_q[brow][bcol];

    assert_choice_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (warg != '0));
endmodule

// File: rtl/gs_results.sv
module gs_results #(
    parameter int W     = 16,
    parameter int N_MAX = 32,
    parameter int G_MAX = 8,
    parameter int IW    = 5,
    parameter int GIW   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_we,
    input  logic [GIW-1:0]      grp_idx,
    input  logic signed [W:0]   grp_thr,
    input  logic [IW-1:0]       grp_lo,
    input  logic [IW-1:0]       grp_hi,
    input  logic                span_we,
    input  logic [W:0]          span_val,
    input  logic [GIW-1:0]      rd_grp_idx,
    output logic signed [W:0]   rd_thr,
    input  logic [IW-1:0]       rd_lvl_idx,
    output logic [GIW-1:0]      rd_lvl_grp,
    output logic [W:0]          span_out
);
    logic signed [W:0] thr_q [G_MAX];
    logic [GIW-1:0]    mem_q [N_MAX];
    logic [W:0]        span_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < G_MAX; g++) thr_q[g] <= '0;
            for (int j = 0; j < N_MAX; j++) mem_q[j] <= '0;
            span_q <= '0;
        end else begin
            if (grp_we) begin
                thr_q[grp_idx] <= grp_thr;
                for (int j = 0; j < N_MAX; j++) begin
                    if (IW'(j) >= grp_lo && IW'(j) <= grp_hi) mem_q[j] <= grp_idx;
                end
            end
            if (span_we) span_q <= span_val;
        end
    end

    assign rd_thr     = thr_q[rd_grp_idx];
    assign rd_lvl_grp = mem_q[rd_lvl_idx];
    assign span_out   = span_q;

    assert_group_bounds_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_we |-> (grp_lo <= grp_hi));
endmodule

// File: rtl/gs_ctrl.sv
module gs_ctrl
    import gsolv_pkg::*;
#(
    parameter int W     = 16,
    parameter int G_MAX = 8,
    parameter int IW    = 5,
    parameter int GIW   = 3,
    parameter int CW    = 6,
    parameter int GW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CW-1:0]       lvl_count,
    input  logic [GW-1:0]       grp_count,
    input  logic signed [W-1:0] lvl_lo,
    input  logic signed [W-1:0] lvl_hi,
    input  logic [W:0]          acost,
    input  logic [W:0]          bcost,
    input  logic [CW-1:0]       barg,
    output logic [IW-1:0]       lo_idx,
    output logic [IW-1:0]       hi_idx,
    output logic                t_we,
    output logic [GIW-1:0]      t_wrow,
    output logic [IW-1:0]       t_wcol,
    output logic [W:0]          t_wcost,
    output logic [CW-1:0]       t_warg,
    output logic [GIW-1:0]      t_arow,
    output logic [IW-1:0]       t_acol,
    output logic [GIW-1:0]      t_brow,
    output logic [IW-1:0]       t_bcol,
    output logic                r_we,
    output logic [GIW-1:0]      r_grp,
    output logic signed [W:0]   r_thr,
    output logic [IW-1:0]       r_lo,
    output logic [IW-1:0]       r_hi,
    output logic                s_we,
    output logic [W:0]          s_val,
    output logic                busy,
    output logic                done,
    output logic                err
);
    gs_state_e     state_q, state_d;
    logic [CW-1:0] m_q, i_q, k_q, n_q, g_q, bestk_q;
    logic [W:0]    best_q;
    logic          err_q;

    logic [CW-1:0] gc_ext, eff_k, lo_c, lo_m1, i_m1, m_m1, m_m2, win_c;
    logic          bad, single_row, first_c, take_c, last_k;
    logic [W:0]    span_c, cand_c, new_best;
    logic [CW-1:0] new_k;

    assign gc_ext = CW'(grp_count);
    assign bad = (gc_ext == '0) || (gc_ext > lvl_count) || (gc_ext > CW'(G_MAX));

    assign eff_k = (state_q == ST_TRACE) ? barg : k_q;
    assign lo_c  = i_q - eff_k;
    assign lo_m1 = (lo_c != '0) ? (lo_c - CW'(1)) : '0;
    assign i_m1  = i_q - CW'(1);
    assign m_m1  = m_q - CW'(1);
    assign m_m2  = (m_q >= CW'(2)) ? (m_q - CW'(2)) : '0;
    assign win_c = i_q - m_q + CW'(1);

    assign single_row = (m_q == CW'(1));
    assign span_c = {lvl_hi[W-1], lvl_hi} - {lvl_lo[W-1], lvl_lo};
    assign cand_c = single_row ? span_c : ((span_c > acost) ? span_c : acost);
    assign first_c  = single_row || (k_q == CW'(1));
    assign take_c   = first_c || (cand_c < best_q);
    assign new_best = take_c ? cand_c : best_q;
    assign new_k    = take_c ? k_q : bestk_q;
    assign last_k   = single_row || (k_q == win_c);

    assign lo_idx  = lo_c[IW-1:0];
    assign hi_idx  = i_m1[IW-1:0];
    assign t_we    = (state_q == ST_FILL) && last_k;
    assign t_wrow  = m_m1[GIW-1:0];
    assign t_wcol  = i_m1[IW-1:0];
    assign t_wcost = new_best;
    assign t_warg  = new_k;
    assign t_arow  = m_m2[GIW-1:0];
    assign t_acol  = lo_m1[IW-1:0];
    assign t_brow  = m_m1[GIW-1:0];
    assign t_bcol  = i_m1[IW-1:0];
    assign r_we    = (state_q == ST_TRACE);
    assign r_grp   = m_m1[GIW-1:0];
    assign r_thr   = {lvl_lo[W-1], lvl_lo} + {lvl_hi[W-1], lvl_hi};
    assign r_lo    = lo_c[IW-1:0];
    assign r_hi    = i_m1[IW-1:0];
    assign s_we    = (state_q == ST_TRACE) && (m_q == g_q);
    assign s_val   = bcost;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = bad ? ST_FIN : ST_FILL;
            ST_FILL:  if (last_k && i_q == n_q && m_q == g_q) state_d = ST_TRACE;
            ST_TRACE: if (m_q == CW'(1)) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            m_q <= '0; i_q <= '0; k_q <= '0; n_q <= '0; g_q <= '0;
            best_q <= '0; bestk_q <= '0; err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        n_q   <= lvl_count;
                        g_q   <= gc_ext;
                        err_q <= bad;
                        m_q   <= CW'(1);
                        i_q   <= CW'(1);
                        k_q   <= CW'(1);
                    end
                end
                ST_FILL: begin
                    if (last_k) begin
                        if (i_q == n_q) begin
                            if (m_q != g_q) begin
                                m_q <= m_q + CW'(1);
                                i_q <= m_q + CW'(1);
                                k_q <= CW'(1);
                            end
                        end else begin
                            i_q <= i_q + CW'(1);
                            k_q <= single_row ? (i_q + CW'(1)) : CW'(1);
                        end
                    end else begin
                        k_q     <= k_q + CW'(1);
                        best_q  <= new_best;
                        bestk_q <= new_k;
                    end
                end
                ST_TRACE: begin
                    i_q <= lo_c;
                    m_q <= m_m1;
                end
                ST_FIN: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state_q == ST_FILL) || (state_q == ST_TRACE);
        done = (state_q == ST_FIN);
        err  = err_q;
    end

    assert_done_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_bad_start_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && bad) |=> (done && err));
    assert_fill_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (k_q >= CW'(1) && k_q <= win_c));
    assert_trace_choice_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACE) |-> (barg >= CW'(1) && barg <= win_c));
    assert_trace_reaches_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACE && m_q == CW'(1)) |-> (barg == i_q));
endmodule

// File: rtl/isi_group_solver.sv
module isi_group_solver #(
    parameter int LVL_W = 16,
    parameter int N_MAX = 32,
    parameter int G_MAX = 8,
    localparam int IW   = $clog2(N_MAX),
    localparam int CW   = $clog2(N_MAX + 1),
    localparam int GW   = $clog2(G_MAX + 1),
    localparam int GIW  = $clog2(G_MAX)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [IW-1:0]           load_idx,
    input  logic signed [LVL_W-1:0] load_level,
    input  logic [CW-1:0]           lvl_count,
    input  logic [GW-1:0]           grp_count,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    input  logic [GIW-1:0]          rd_grp_idx,
    output logic signed [LVL_W:0]   rd_thr,
    input  logic [IW-1:0]           rd_lvl_idx,
    output logic [GIW-1:0]          rd_lvl_grp,
    output logic [LVL_W:0]          span_max
);
    logic [IW-1:0]           lo_idx, hi_idx;
    logic signed [LVL_W-1:0] lvl_lo, lvl_hi;
    logic                    t_we;
    logic [GIW-1:0]          t_wrow, t_arow, t_brow;
    logic [IW-1:0]           t_wcol, t_acol, t_bcol;
    logic [LVL_W:0]          t_wcost, acost, bcost;
    logic [CW-1:0]           t_warg, barg;
    logic                    r_we, s_we;
    logic [GIW-1:0]          r_grp;
    logic signed [LVL_W:0]   r_thr;
    logic [IW-1:0]           r_lo, r_hi;
    logic [LVL_W:0]          s_val;
    logic                    busy_w;

    assign busy = busy_w;

    gs_levels #(.W(LVL_W), .N_MAX(N_MAX), .IW(IW)) u_levels (
        .clk(clk), .rst_n(rst_n),
        .wr_en(load_en && !busy_w), .wr_idx(load_idx), .wr_val(load_level),
        .rd_lo_idx(lo_idx), .rd_hi_idx(hi_idx), .rd_lo(lvl_lo), .rd_hi(lvl_hi)
    );

    gs_table #(.W(LVL_W), .N_MAX(N_MAX), .G_MAX(G_MAX), .IW(IW), .GIW(GIW), .CW(CW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(t_we), .wrow(t_wrow), .wcol(t_wcol), .wcost(t_wcost), .warg(t_warg),
        .arow(t_arow), .acol(t_acol), .acost(acost),
        .brow(t_brow), .bcol(t_bcol), .bcost(bcost), .barg(barg)
    );

    gs_ctrl #(.W(LVL_W), .G_MAX(G_MAX), .IW(IW), .GIW(GIW), .CW(CW), .GW(GW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .lvl_count(lvl_count), .grp_count(grp_count),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .acost(acost), .bcost(bcost), .barg(barg),
        .lo_idx(lo_idx), .hi_idx(hi_idx),
        .t_we(t_we), .t_wrow(t_wrow), .t_wcol(t_wcol), .t_wcost(t_wcost), .t_warg(t_warg),
        .t_arow(t_arow), .t_acol(t_acol), .t_brow(t_brow), .t_bcol(t_bcol),
        .r_we(r_we), .r_grp(r_grp), .r_thr(r_thr), .r_lo(r_lo), .r_hi(r_hi),
        .s_we(s_we), .s_val(s_val),
        .busy(busy_w), .done(done), .err(err)
    );

    gs_results #(.W(LVL_W), .N_MAX(N_MAX), .G_MAX(G_MAX), .IW(IW), .GIW(GIW)) u_results (
        .clk(clk), .rst_n(rst_n),
        .grp_we(r_we), .grp_idx(r_grp), .grp_thr(r_thr), .grp_lo(r_lo), .grp_hi(r_hi),
        .span_we(s_we), .span_val(s_val),
        .rd_grp_idx(rd_grp_idx), .rd_thr(rd_thr),
        .rd_lvl_idx(rd_lvl_idx), .rd_lvl_grp(rd_lvl_grp), .span_out(span_max)
    );
endmodule

// File: tb/sim_isi_group_solver.sv
module sim_isi_group_solver;
    localparam int W = 16, NM = 32, GM = 8;
    localparam int IW = 5, CW = 6, GW = 4, GIW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_en = 1'b0, start = 1'b0;
    logic [IW-1:0] load_idx = '0, rd_lvl_idx = '0;
    logic signed [W-1:0] load_level = '0;
    logic [CW-1:0] lvl_count = '0;
    logic [GW-1:0] grp_count = '0;
    logic [GIW-1:0] rd_grp_idx = '0, rd_lvl_grp;
    logic busy, done, err;
    logic signed [W:0] rd_thr;
    logic [W:0] span_max;

    int total = 0, bad = 0;
    int lv [NM];
    int ecost [GM+1][NM+1];
    int earg [GM+1][NM+1];
    int egrp [NM];
    int ethr [GM];
    int espan;
    int rng = 12345;
    int snap_thr [GM];
    int snap_grp [NM];
    int snap_span;

    always #2 clk = ~clk;

    isi_group_solver u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_level(load_level), .lvl_count(lvl_count), .grp_count(grp_count),
        .start(start), .busy(busy), .done(done), .err(err),
        .rd_grp_idx(rd_grp_idx), .rd_thr(rd_thr), .rd_lvl_idx(rd_lvl_idx),
        .rd_lvl_grp(rd_lvl_grp), .span_max(span_max)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt(input int mod);
        rng = (rng * 1103515245 + 12345) & 32'h7fffffff;
        return (rng >>> 8) % mod;
    endfunction

    task automatic gen(input int n, input int mode);
        int v = -200 + nxt(50);
        for (int j = 0; j < n; j++) begin
            lv[j] = v;
            case (mode)
                0: v += nxt(16);
                1: v += 0;
                2: v += ((j % 4) == 3) ? 60 + nxt(20) : nxt(3);
                default: v += (nxt(2) == 0) ? 0 : 25;
            endcase
        end
    endtask

    task automatic load(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = IW'(j); load_level = W'(lv[j]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic model(input int n, input int m);
        for (int i = 1; i <= n; i++) begin
            ecost[1][i] = lv[i-1] - lv[0];
            earg[1][i] = i;
        end
        for (int g = 2; g <= m; g++) begin
            for (int i = g; i <= n; i++) begin
                int best = 32'h7fffffff;
                for (int k = 1; k <= i - g + 1; k++) begin
                    int sp = lv[i-1] - lv[i-k];
                    int c = (sp > ecost[g-1][i-k]) ? sp : ecost[g-1][i-k];
                    if (c < best) begin best = c; earg[g][i] = k; end
                end
                ecost[g][i] = best;
            end
        end
        espan = ecost[m][n];
        begin
            int i = n;
            for (int g = m; g >= 1; g--) begin
                int k = earg[g][i];
                ethr[g-1] = lv[i-k] + lv[i-1];
                for (int j = i - k; j < i; j++) egrp[j] = g - 1;
                i = i - k;
            end
        end
    endtask

    // Starts a run; optional disturbance mid-run (1: start again, 2: load slot 0).
    task automatic run(input int n, input int m, input int disturb);
        int cyc = 0;
        @(negedge clk);
        lvl_count = CW'(n); grp_count = GW'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        while (!done && cyc < 20000) begin
            if (cyc == 2 && disturb == 1) begin
                grp_count = GW'(1); start = 1'b1;
            end else if (cyc == 2 && disturb == 2) begin
                load_en = 1'b1; load_idx = '0; load_level = 16'sd20000;
            end else begin
                start = 1'b0; load_en = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; load_en = 1'b0;
        check(done == 1'b1, "R8 run reaches done", int'(done), 1);
        check(err == 1'b0, "R7 no error on legal count", int'(err), 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 done lasts one cycle", int'(done), 0);
    endtask

    task automatic compare(input int n, input int m, input string tag);
        check(int'(span_max) == espan, {tag, " R3 minimax span"}, int'(span_max), espan);
        for (int g = 0; g < m; g++) begin
            rd_grp_idx = GIW'(g); #1;
            check(int'(rd_thr) == ethr[g], {tag, " R4 threshold"}, int'(rd_thr), ethr[g]);
        end
        for (int j = 0; j < n; j++) begin
            rd_lvl_idx = IW'(j); #1;
            check(int'(rd_lvl_grp) == egrp[j], {tag, " R5/R6 membership"}, int'(rd_lvl_grp), egrp[j]);
        end
    endtask

    task automatic snapshot();
        snap_span = int'(span_max);
        for (int g = 0; g < GM; g++) begin rd_grp_idx = GIW'(g); #1; snap_thr[g] = int'(rd_thr); end
        for (int j = 0; j < NM; j++) begin rd_lvl_idx = IW'(j); #1; snap_grp[j] = int'(rd_lvl_grp); end
    endtask

    task automatic bad_start(input int n, input int m);
        snapshot();
        @(negedge clk);
        lvl_count = CW'(n); grp_count = GW'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && err == 1'b1, "R7 error flagged next cycle", int'(err), 1);
        check(int'(span_max) == snap_span, "R7 span kept", int'(span_max), snap_span);
        for (int g = 0; g < GM; g++) begin
            rd_grp_idx = GIW'(g); #1;
            check(int'(rd_thr) == snap_thr[g], "R7 threshold kept", int'(rd_thr), snap_thr[g]);
        end
        for (int j = 0; j < NM; j++) begin
            rd_lvl_idx = IW'(j); #1;
            check(int'(rd_lvl_grp) == snap_grp[j], "R7 membership kept", int'(rd_lvl_grp), snap_grp[j]);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "reset idle", int'(busy), 0);
        check(span_max == '0, "reset span", int'(span_max), 0);

        // R6 tie: levels 0,5,10 in two groups -> {0,5},{10}, span 5
        lv[0] = 0; lv[1] = 5; lv[2] = 10;
        load(3); run(3, 2, 0);
        rd_lvl_idx = 5'd1; #1;
        check(rd_lvl_grp == 3'd0, "R6 tie keeps level 1 in group 0", int'(rd_lvl_grp), 0);
        rd_lvl_idx = 5'd2; #1;
        check(rd_lvl_grp == 3'd1, "R6 tie level 2 alone", int'(rd_lvl_grp), 1);
        check(span_max == 17'd5, "R6 tie span", int'(span_max), 5);

        // Sweep: R1 loads, R2 single group, R3..R6 every legal group count
        for (int mode = 0; mode < 4; mode++) begin
            for (int n = 1; n <= 9; n++) begin
                gen(n, mode); load(n);
                for (int m = 1; m <= ((n < GM) ? n : GM); m++) begin
                    model(n, m); run(n, m, 0);
                    compare(n, m, (m == 1) ? "R2 R1" : "R1");
                end
            end
        end

        // Full-size runs
        gen(NM, 2); load(NM);
        model(NM, GM); run(NM, GM, 0); compare(NM, GM, "full R3");
        model(NM, 1); run(NM, 1, 0); compare(NM, 1, "full R2");
        gen(20, 0); load(20);
        model(20, 5); run(20, 5, 0); compare(20, 5, "mid R3");

        // R8 start during busy ignored; R9 load during busy ignored
        model(20, 5); run(20, 5, 1); compare(20, 5, "R8 restart ignored");
        model(20, 5); run(20, 5, 2); compare(20, 5, "R9 load ignored");

        // R7 illegal counts
        bad_start(20, 0);
        bad_start(3, 4);
        bad_start(20, 9);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule